// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter that runs from a system clock split into four phases, Q1 to Q4. Each phase lasts one input-clock period, and four phases make one instruction cycle. The timer counts either instruction cycles or active transitions of an external pin. The edge_fall input picks which transition is active.

One 8-bit prescaler counter is shared by two users, and it serves only one of them at a time. A field in the option register gives it either to the timer, where it divides the count source, or to a watchdog tick input, where it divides that tick. The same register also holds the division ratio and the clock-source choice.

The external count source is sampled at two points in each instruction cycle, on Q2 and on Q4. This source is either the synchronised pin or the prescaler tap, depending on ownership. The timer only ever advances on the clock edge that closes Q4. A write to the timer loads a new value. Counting then pauses for two instruction cycles before it resumes.

Top module: `tmr_shared_ps`

## Requirements
- R1: After reset, tmr_val is 0x00, tmr_ovf and wdt_tick_out are 0, the option register is 0x00, and the phase counter is at Q1.
- R2: A write with wr_sel=1 loads the option register. Bits [2:0] hold the ratio code n. Bit 3 set means the prescaler belongs to the watchdog, and clear means it belongs to the timer. Bit 5 set selects the external pin as the count source, and clear selects instruction cycles.
- R3: tmr_val changes only on a timer write, or on the clock edge that ends Q4. The first edge after reset ends Q1, so Q4 ends on every fourth edge.
- R4: When the prescaler belongs to the watchdog and the source is internal, the timer advances by exactly one per four clocks.
- R5: A write with wr_sel=0 loads wr_data into tmr_val on that edge. The next two Q4 edges after the write do not advance the timer.
- R6: The timer wraps from 0xFF to 0x00, and tmr_ovf is high for exactly the one clock that follows the wrap.
- R7: With the external source and no timer prescaler, each active pin transition advances the timer once, within 8 clocks. Active means rising when edge_fall=0 and falling when edge_fall=1. Pin levels are held for at least 4 clocks.
- R8: When the prescaler belongs to the timer, ratio code n gives one timer increment per 2^(n+1) count events. A count event is an active pin transition or an instruction cycle, depending on the source.
- R9: When the prescaler belongs to the timer, a timer write clears the prescaler count.
- R10: When the prescaler belongs to the watchdog, ratio code n gives one wdt_tick_out pulse for every 2^n wdt_tick_in pulses. The pulse appears on the clock after the tick that completes the group.
- R11: When the prescaler belongs to the watchdog, wdt_clr clears the prescaler count. A tick that arrives in the same clock as wdt_clr is discarded.
- R12: When the prescaler belongs to the timer, wdt_tick_out repeats wdt_tick_in one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one period is one phase |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the timer, 1 selects the option register |
| wr_data | input | 8 | Write data |
| wdt_tick_in | input | 1 | Raw watchdog tick, one clock wide |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ext_clk | input | 1 | External count pin, asynchronous |
| edge_fall | input | 1 | 1 makes the falling pin transition active |
| tmr_val | output | 8 | Current timer value |
| tmr_ovf | output | 1 | One-clock pulse on wrap to zero |
| wdt_tick_out | output | 1 | Watchdog tick after the postscaler |

## Verification
A prescaler count left uncleared shows up as an increment or a watchdog pulse that comes a partial group too early. A check right after the first full group of events exposes it. A phase counter out of step shows as a tmr_val change on an edge that does not close Q4, which the port monitor flags within one instruction cycle. A wrong tap or mask selection changes the ratio. This appears as a miscount after a few groups of events or ticks, where each group holds 2^(n+1) or 2^n of them.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_t;
  localparam int OPT_W       = 8;
  localparam int OPT_RAT_LSB = 0;
  localparam int OPT_PSA_BIT = 3;
  localparam int OPT_SRC_BIT = 5;
endpackage

// File: rtl/tsp_phase_gen.sv
module tsp_phase_gen (
  input  logic            clk,
  input  logic            rst,
  output tsp_pkg::phase_t ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= tsp_pkg::PH_Q1;
    else     ph <= tsp_pkg::phase_t'(ph + 2'd1);
  end
endmodule

// File: rtl/tsp_edge_sync.sv
module tsp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic invert,
  output logic lvl,
  output logic evt
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      lvl_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      lvl_d  <= lvl;
    end
  end

  // polarity-adjusted level: the active transition is always a rise here
  assign lvl = sync_q[STAGES-1] ^ invert;
  assign evt = lvl & ~lvl_d;
endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt,
  input  logic            clr,
  output logic [PS_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (evt)   cnt <= cnt + PS_W'(1);
  end
endmodule

// File: rtl/tmr_shared_ps.sv
module tmr_shared_ps #(
  parameter int TMR_W       = 8,
  parameter int PS_W        = 8,
  parameter int RAT_W       = 3,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             wdt_tick_in,
  input  logic             wdt_clr,
  input  logic             ext_clk,
  input  logic             edge_fall,
  output logic [TMR_W-1:0] tmr_val,
  output logic             tmr_ovf,
  output logic             wdt_tick_out
);
  import tsp_pkg::*;

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  phase_t                ph;
  logic [OPT_W-1:0]      opt_q;
  logic                  opt_psa, opt_src;
  logic [RAT_W-1:0]      opt_rat;
  logic                  wr_tmr, wr_opt;
  logic                  q2, q4;
  logic                  ext_lvl, ext_evt;
  logic                  ps_evt, ps_clr;
  logic [PS_W-1:0]       ps_cnt;
  logic [PS_W-1:0]       wd_mask;
  logic                  src_lvl, samp_q, pend_q, rise_now, direct_int, inc;
  logic [HOLD_W-1:0]     hold_q;

  assign opt_psa = opt_q[OPT_PSA_BIT];
  assign opt_src = opt_q[OPT_SRC_BIT];
  assign opt_rat = opt_q[OPT_RAT_LSB +: RAT_W];
  assign wr_tmr  = wr_en & ~wr_sel;
  assign wr_opt  = wr_en &  wr_sel;
  assign q2      = (ph == PH_Q2);
  assign q4      = (ph == PH_Q4);

  tsp_phase_gen u_phase (.clk(clk), .rst(rst), .ph(ph));

  tsp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_clk), .invert(edge_fall),
    .lvl(ext_lvl), .evt(ext_evt)
  );

  // one counter, one owner: the watchdog tick or the timer count source
  assign ps_evt = opt_psa ? wdt_tick_in : (opt_src ? ext_evt : q4);
  assign ps_clr = opt_psa ? wdt_clr : wr_tmr;

  tsp_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .evt(ps_evt), .clr(ps_clr), .cnt(ps_cnt)
  );

  // tap n falls every 2^(n+1) events; its inverse rises there
  assign src_lvl    = opt_psa ? ext_lvl : ~ps_cnt[opt_rat];
  assign direct_int = opt_psa & ~opt_src;

  // two sample points per instruction cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (q2) begin
      samp_q <= src_lvl;
      pend_q <= src_lvl & ~samp_q;
    end else if (q4) begin
      samp_q <= src_lvl;
      pend_q <= 1'b0;
    end
  end

  assign rise_now = pend_q | (src_lvl & ~samp_q);
  assign inc      = direct_int | rise_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q <= '0;
    end else if (wr_opt) begin
      opt_q <= wr_data[OPT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_val <= '0;
      tmr_ovf <= 1'b0;
      hold_q  <= '0;
    end else if (wr_tmr) begin
      tmr_val <= wr_data;
      tmr_ovf <= 1'b0;
      hold_q  <= HOLD_W'(HOLD_CYC);
    end else begin
      tmr_ovf <= 1'b0;
      if (q4) begin
        if (hold_q != '0) begin
          hold_q <= hold_q - HOLD_W'(1);
        end else if (inc) begin
          tmr_val <= tmr_val + TMR_W'(1);
          tmr_ovf <= &tmr_val;
        end
      end
    end
  end

  assign wd_mask = (PS_W'(1) << opt_rat) - PS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_tick_out <= 1'b0;
    end else if (opt_psa) begin
      wdt_tick_out <= wdt_tick_in & ~wdt_clr & ((ps_cnt & wd_mask) == wd_mask);
    end else begin
      wdt_tick_out <= wdt_tick_in;
    end
  end
endmodule

// File: rtl/tmr_shared_ps_chk.sv
module tmr_shared_ps_chk #(
  parameter int TMR_W = 8,
  parameter int PS_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [TMR_W-1:0] wr_data,
  input logic             wdt_tick_in,
  input logic             wdt_clr,
  input logic [TMR_W-1:0] tmr_val,
  input logic             tmr_ovf,
  input logic             wdt_tick_out,
  input logic [1:0]       ph,
  input logic             psa,
  input logic [PS_W-1:0]  ps_cnt
);
  assert_q4_only_R3: assert property (@(posedge clk) disable iff (rst)
    (tmr_val != $past(tmr_val)) |-> ($past(ph) == 2'd3 || $past(wr_en && !wr_sel)));

  assert_write_load_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !wr_sel) |-> (tmr_val == $past(wr_data)));

  assert_ovf_single_R6: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> !tmr_ovf);

  assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |-> (tmr_val == '0 && $past(tmr_val) == {TMR_W{1'b1}}));

  assert_wdt_needs_tick_R10: assert property (@(posedge clk) disable iff (rst)
    wdt_tick_out |-> $past(wdt_tick_in));

  assert_wdt_clr_R11: assert property (@(posedge clk) disable iff (rst)
    $past(wdt_clr && psa) |-> (ps_cnt == '0));
endmodule

bind tmr_shared_ps tmr_shared_ps_chk #(.TMR_W(TMR_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wdt_tick_in(wdt_tick_in), .wdt_clr(wdt_clr), .tmr_val(tmr_val),
  .tmr_ovf(tmr_ovf), .wdt_tick_out(wdt_tick_out), .ph(ph),
  .psa(opt_psa), .ps_cnt(ps_cnt)
);

// File: tb/tmr_shared_ps_tb.sv
module tmr_shared_ps_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wdt_tick_in = 1'b0, wdt_clr = 1'b0, ext_clk = 1'b0, edge_fall = 1'b0;
  logic [7:0] tmr_val;
  logic       tmr_ovf, wdt_tick_out;

  int checks = 0, failures = 0;
  int ovf_seen = 0, wdt_seen = 0, bad_phase = 0, ecnt = 0;
  logic wr_last = 1'b0;
  logic [7:0] prev_tmr = '0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_shared_ps u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wdt_tick_in(wdt_tick_in), .wdt_clr(wdt_clr), .ext_clk(ext_clk),
    .edge_fall(edge_fall), .tmr_val(tmr_val), .tmr_ovf(tmr_ovf),
    .wdt_tick_out(wdt_tick_out)
  );

  always @(posedge clk) begin
    if (rst) ecnt <= 0; else ecnt <= ecnt + 1;
    wr_last <= wr_en && !wr_sel;
  end

  // port monitor: pulse counts and the Q4-only rule (R3)
  always @(negedge clk) begin
    if (!rst) begin
      if (tmr_ovf) ovf_seen++;
      if (wdt_tick_out) wdt_seen++;
      if (tmr_val != prev_tmr && !wr_last && (ecnt % 4) != 0) bad_phase++;
    end
    prev_tmr = tmr_val;
  end

  function automatic int exp_div(input int events, input int shift);
    return events >> shift;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_edges(input int k);
    for (int i = 0; i < k; i++) begin
      ext_clk = ~ext_clk; tick(4);
      ext_clk = ~ext_clk; tick(4);
    end
  endtask

  task automatic wd_ticks(input int k);
    for (int i = 0; i < k; i++) begin
      wdt_tick_in = 1'b1; tick(1);
      wdt_tick_in = 1'b0; tick(1);
    end
  endtask

  task automatic wd_clear();
    wdt_clr = 1'b1; tick(1); wdt_clr = 1'b0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, k, v0;
    void'($urandom(32'd1234));
    tick(5);
    check("R1 tmr", tmr_val, 0);
    check("R1 ovf", tmr_ovf, 0);
    check("R1 wdt", wdt_tick_out, 0);
    rst = 1'b0;

    // R4 / R5: internal source, prescaler owned by watchdog (bit3)
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h40);
    tick(8);  check("R5 hold two cycles", tmr_val, 8'h40);
    tick(4);  check("R5 resume", tmr_val, 8'h41);
    tick(40); check("R4 one per 4 clocks", tmr_val, 8'h4B);

    // R6 wrap
    ovf_seen = 0;
    wr(1'b0, 8'hFE);
    tick(16);
    check("R6 wrap value", tmr_val, 0);
    check("R6 ovf pulses", ovf_seen, 1);

    // R7 external 1:1 rising (bit5 src ext, bit3 watchdog owns prescaler)
    edge_fall = 1'b0; ext_clk = 1'b0;
    wr(1'b1, 8'h28);
    wr(1'b0, 8'h00); tick(12);
    ext_edges(5); tick(8);
    check("R7 rising count", tmr_val, 5);
    ext_clk = 1'b1; tick(8);
    check("R7 latency", tmr_val, 6);
    ext_clk = 1'b0; tick(4);
    // R7 falling
    edge_fall = 1'b1; ext_clk = 1'b1; tick(4);
    wr(1'b0, 8'h00); tick(12);
    ext_edges(3); tick(8);
    check("R7 falling count", tmr_val, 3);

    // R8 random ratios, external source, prescaler owned by timer
    edge_fall = 1'b0; ext_clk = 1'b0; tick(4);
    for (int it = 0; it < 4; it++) begin
      n = $urandom % 6;
      k = $urandom_range(1, 3 * (2 << n));
      wr(1'b1, 8'h20 | n[7:0]);
      wr(1'b0, 8'h00); tick(12);
      ext_edges(k); tick(8);
      check("R8 ext ratio", tmr_val, exp_div(k, n + 1));
    end
    wr(1'b1, 8'h27);
    wr(1'b0, 8'h00); tick(12);
    ext_edges(256); tick(8);
    check("R8 ratio 1:256", tmr_val, 1);

    // R9 timer write clears prescaler (ratio 2 -> 1:8)
    wr(1'b1, 8'h22);
    wr(1'b0, 8'h00); tick(12);
    ext_edges(5);
    wr(1'b0, 8'h10); tick(12);
    ext_edges(3); tick(8);
    check("R9 partial group lost", tmr_val, 8'h10);
    ext_edges(5); tick(8);
    check("R9 fresh group", tmr_val, 8'h11);

    // R8 internal source with prescaler 1:4 (R2 field decode)
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h00); tick(12);
    v0 = tmr_val;
    tick(160);
    check_range("R8 internal 1:4 rate", tmr_val - v0, 9, 11);

    // R10 watchdog postscaler
    wr(1'b1, 8'h08);
    wd_clear();
    wdt_tick_in = 1'b1; tick(1); wdt_tick_in = 1'b0;
    check("R10 1:1 next clock", wdt_tick_out, 1);
    tick(2);
    for (int it = 0; it < 4; it++) begin
      n = $urandom % 8;
      k = $urandom_range(1, 3 * (1 << n));
      wr(1'b1, 8'h08 | n[7:0]);
      wd_clear();
      wdt_seen = 0;
      wd_ticks(k); tick(2);
      check("R10 postscale count", wdt_seen, exp_div(k, n));
    end

    // R11 clear discards progress and a coincident tick
    wr(1'b1, 8'h0A);
    wd_clear(); wdt_seen = 0;
    wd_ticks(3); wd_clear(); wd_ticks(3); tick(2);
    check("R11 clear restarts group", wdt_seen, 0);
    wdt_tick_in = 1'b1; wdt_clr = 1'b1; tick(1);
    wdt_tick_in = 1'b0; wdt_clr = 1'b0; tick(1);
    wd_ticks(3); tick(2);
    check("R11 coincident tick dropped", wdt_seen, 0);
    wd_ticks(1); tick(2);
    check("R11 group completes", wdt_seen, 1);

    // R12 timer-owned prescaler: watchdog passes through
    wr(1'b1, 8'h03);
    wdt_seen = 0;
    wd_ticks(5); tick(2);
    check("R12 pass-through", wdt_seen, 5);

    check("R3 off-phase changes", bad_phase, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule